// File: doc/BRIEF.md
# Sleep-State Wake Event Qualifier

This block collects wake requests from every wake-capable source of a platform power-management unit and decides whether each one is allowed to wake the system. The sources are the real-time-clock alarm, the power button, LAN, ring indicate, the audio codec, the primary and secondary power-management events, the internal USB controller event, the SMBus alert, SMBus slave wake and hard-reset commands, SMBus host notify, the core-well and resume-well general-purpose inputs, and the per-controller USB wakes. A request counts only if its enable bit is set (or the source cannot be masked), and only if the current sleep state and the way S5 was entered allow it. A qualified request produces a one-cycle registered wake pulse.

Every source also owns a sticky status bit. The bit is set by the raw event whatever the enable or the sleep state, and software clears it by writing 1. The block remembers whether S5 was entered through a power-button override, which restricts wake to a small set of sources until the system returns to S0.

Top module: `wakeQual`

## Requirements
- R1: Each `srcEvt` bit sets the `status` bit of the same index on the next clock edge, whatever `srcEn`, the sleep state or the override flag. Index map: 0 RTC alarm, 1 power button, 2 LAN, 3 ring indicate, 4 audio codec, 5 primary PME, 6 secondary PME, 7 internal USB-controller PME, 8 SMBus alert, 9 SMBus slave wake, 10 SMBus hard reset without cycling, 11 SMBus hard reset system, 12 SMBus host notify, 13..20 core-well GPIs 0..7, 21..24 resume-well GPIs (8, 11, 12, 13), 25..27 USB controllers 1..3.
- R2: A 1 on a `statusClr` bit clears that status bit on the next edge; a bit held at 0 keeps its value; an event on the same bit in the same cycle wins over the clear.
- R3: `sleepState` is encoded 0 = S0 and 1..5 = S1..S5; codes 6 and 7 count as awake. `wakeOut` is high for exactly the cycle after a cycle in which at least one qualified event was present, and it is never raised for events seen in S0 or in codes 6 and 7.
- R4: Sources 0, 3..7, 12 and 13..27 wake only when their `srcEn` bit is 1. Sources 1, 2, 8, 9, 10 and 11 ignore their `srcEn` bit.
- R5: Core-well GPIs (indices 13..20) may wake only from S1.
- R6: While in S5 with the override flag set, only indices 1, 9, 10 and 11 may wake.
- R7: In S2..S4, and in S5 entered by software (override flag clear), every source except the core-well GPIs may wake when enabled, including the resume-well GPIs and the USB controllers.
- R8: A high `overrideEntry` in a cycle with `sleepState` not 0 sets the override flag from the next cycle on; any cycle with `sleepState` = 0 clears it from the next cycle on, and clearing wins.
- R9: After reset `wakeOut` is 0, all status bits are 0 and the override flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepState | input | 3 | Current sleep state, 0 = S0, 1..5 = S1..S5 |
| overrideEntry | input | 1 | Pulse: S5 is being entered by power-button override |
| srcEvt | input | 28 | One-cycle event pulse per source |
| srcEn | input | 28 | Enable bit per source |
| statusClr | input | 28 | Write-1-to-clear strobe per status bit |
| wakeOut | output | 1 | Registered one-cycle wake pulse |
| status | output | 28 | Sticky status bits |

## Verification
The hardest situation to reach is an event arriving in S5 while the override flag is set, since the flag is internal and must first be armed by an `overrideEntry` pulse and only drops after a visit to S0. The stimulus walks the state randomly and, when it moves into S5, pulses `overrideEntry` half of the time, so override-S5 and software-S5 periods both last many cycles while sparse single- and double-bit events land in them. Directed sequences also arm the flag, show that a maskable source is blocked while the power button still wakes, then pass through S0 and show the same source waking from a software S5.

// File: rtl/wakeQualPkg.sv
package wakeQualPkg;

  localparam int IDX_RTC        = 0;
  localparam int IDX_PWR_BTN    = 1;
  localparam int IDX_LAN        = 2;
  localparam int IDX_SMB_ALERT  = 8;
  localparam int IDX_SMB_WAKE   = 9;
  localparam int IDX_SMB_HR_NC  = 10;
  localparam int IDX_SMB_HR_SYS = 11;
  localparam int NUM_FIXED      = 13;

  typedef struct packed {
    logic inSleep;
    logic inS1;
    logic s5Ovr;
  } wakeGateT;

  function automatic bit isUnmaskable(int i);
    return i == IDX_PWR_BTN || i == IDX_LAN || i == IDX_SMB_ALERT ||
           i == IDX_SMB_WAKE || i == IDX_SMB_HR_NC || i == IDX_SMB_HR_SYS;
  endfunction

  function automatic bit isOverrideWaker(int i);
    return i == IDX_PWR_BTN || i == IDX_SMB_WAKE ||
           i == IDX_SMB_HR_NC || i == IDX_SMB_HR_SYS;
  endfunction

endpackage

// File: rtl/wakeQualCtrl.sv
module wakeQualCtrl
  import wakeQualPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] sleepState,
  input  logic       overrideEntry,
  output wakeGateT   gate
);

  logic ovrFlag;
  logic isS0;
  logic isSleep;

  assign isS0    = (sleepState == 3'd0);
  assign isSleep = (sleepState >= 3'd1) && (sleepState <= 3'd5);

  always_ff @(posedge clk) begin
    if (!rstN)              ovrFlag <= 1'b0;
    else if (isS0)          ovrFlag <= 1'b0;
    else if (overrideEntry) ovrFlag <= 1'b1;
  end

  always_comb begin
    gate.inSleep = isSleep;
    gate.inS1    = (sleepState == 3'd1);
    gate.s5Ovr   = (sleepState == 3'd5) && ovrFlag;
  end

  AST_OVR_CLEARS_IN_S0: assert property (@(posedge clk) disable iff (!rstN)
    isS0 |=> !ovrFlag);                                           // R8
  AST_OVR_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (overrideEntry && !isS0) |=> ovrFlag);                        // R8
  AST_GATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gate.inS1, gate.s5Ovr}));                           // R5

endmodule

// File: rtl/wakeQualPath.sv
module wakeQualPath
  import wakeQualPkg::*;
#(
  parameter int NUM_CORE_GPI   = 8,
  parameter int NUM_RESUME_GPI = 4,
  parameter int NUM_USB        = 3,
  localparam int NUM_SRC = NUM_FIXED + NUM_CORE_GPI + NUM_RESUME_GPI + NUM_USB
)(
  input  logic               clk,
  input  logic               rstN,
  input  wakeGateT           gate,
  input  logic [NUM_SRC-1:0] srcEvt,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] statusClr,
  output logic               wakeOut,
  output logic [NUM_SRC-1:0] status
);

  localparam int CORE_LO = NUM_FIXED;
  localparam int CORE_HI = NUM_FIXED + NUM_CORE_GPI;

  logic [NUM_SRC-1:0] allowBit;
  logic [NUM_SRC-1:0] enBit;
  logic [NUM_SRC-1:0] qualEvt;
  logic [NUM_SRC-1:0] overrideSet;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    if (isUnmaskable(g)) begin : gAlways
      assign enBit[g] = 1'b1 | srcEn[g];
    end else begin : gMasked
      assign enBit[g] = srcEn[g];
    end

    if (isOverrideWaker(g)) begin : gAny
      assign allowBit[g]    = gate.inSleep;
      assign overrideSet[g] = 1'b1;
    end else if (g >= CORE_LO && g < CORE_HI) begin : gCore
      assign allowBit[g]    = gate.inS1;
      assign overrideSet[g] = 1'b0;
    end else begin : gNormal
      assign allowBit[g]    = gate.inSleep && !gate.s5Ovr;
      assign overrideSet[g] = 1'b0;
    end
  end

  assign qualEvt = srcEvt & enBit & allowBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeOut <= 1'b0;
      status  <= '0;
    end else begin
      wakeOut <= |qualEvt;
      status  <= (status & ~statusClr) | srcEvt;
    end
  end

  AST_WAKE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> $past(|srcEvt));                                  // R3
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> $past(gate.inSleep));                             // R3
  AST_OVR_LIMITED: assert property (@(posedge clk) disable iff (!rstN)
    (wakeOut && $past(gate.s5Ovr)) |-> $past(|(srcEvt & overrideSet))); // R6
  AST_STATUS_SETS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(srcEvt)) == $past(srcEvt)));        // R1
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(status & ~statusClr)) == $past(status & ~statusClr))); // R2

endmodule

// File: rtl/wakeQual.sv
module wakeQual
  import wakeQualPkg::*;
#(
  parameter int NUM_CORE_GPI   = 8,
  parameter int NUM_RESUME_GPI = 4,
  parameter int NUM_USB        = 3,
  localparam int NUM_SRC = NUM_FIXED + NUM_CORE_GPI + NUM_RESUME_GPI + NUM_USB
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         sleepState,
  input  logic               overrideEntry,
  input  logic [NUM_SRC-1:0] srcEvt,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] statusClr,
  output logic               wakeOut,
  output logic [NUM_SRC-1:0] status
);

  wakeGateT gate;

  wakeQualCtrl i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .sleepState    (sleepState),
    .overrideEntry (overrideEntry),
    .gate          (gate)
  );

  wakeQualPath #(
    .NUM_CORE_GPI   (NUM_CORE_GPI),
    .NUM_RESUME_GPI (NUM_RESUME_GPI),
    .NUM_USB        (NUM_USB)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .gate      (gate),
    .srcEvt    (srcEvt),
    .srcEn     (srcEn),
    .statusClr (statusClr),
    .wakeOut   (wakeOut),
    .status    (status)
  );

endmodule

// File: tb/test_wakeQual.sv
`timescale 1ns/1ps
module test_wakeQual;

  localparam int W = 28;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   sleepState = '0;
  logic         overrideEntry = 1'b0;
  logic [W-1:0] srcEvt = '0;
  logic [W-1:0] srcEn = '0;
  logic [W-1:0] statusClr = '0;
  logic         wakeOut;
  logic [W-1:0] status;

  int checks = 0;
  int errors = 0;
  bit mOvr = 1'b0;
  logic [W-1:0] mStat = '0;

  always #5 clk = ~clk;

  wakeQual i_wakeQual (
    .clk(clk), .rstN(rstN), .sleepState(sleepState), .overrideEntry(overrideEntry),
    .srcEvt(srcEvt), .srcEn(srcEn), .statusClr(statusClr),
    .wakeOut(wakeOut), .status(status)
  );

  function automatic bit expWake(logic [2:0] st, bit ovr, logic [W-1:0] ev, logic [W-1:0] en);
    bit asleep = (st >= 3'd1 && st <= 3'd5);
    bit res = 1'b0;
    for (int i = 0; i < W; i++) begin
      bit always1 = (i == 1 || i == 2 || i == 8 || i == 9 || i == 10 || i == 11);
      bit anyState = (i == 1 || i == 9 || i == 10 || i == 11);
      bit core = (i >= 13 && i <= 20);
      bit allow = anyState ? asleep : core ? (st == 3'd1) : (asleep && !(st == 3'd5 && ovr));
      if (ev[i] && (en[i] || always1) && allow) res = 1'b1;
    end
    return res;
  endfunction

  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic checkVec(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle, let the edge pass, then check wake and status
  task automatic step(string tag, logic [2:0] st, bit ovrIn, logic [W-1:0] ev,
                      logic [W-1:0] en, logic [W-1:0] clr);
    bit ew;
    @(negedge clk);
    sleepState = st; overrideEntry = ovrIn; srcEvt = ev; srcEn = en; statusClr = clr;
    ew = expWake(st, mOvr, ev, en);
    mStat = (mStat & ~clr) | ev;
    if (st == 3'd0) mOvr = 1'b0;
    else if (ovrIn) mOvr = 1'b1;
    @(posedge clk);
    #1;
    checkBit({tag, " wake"}, wakeOut, ew);
    checkVec({tag, " status"}, status, mStat);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] st = 3'd0;
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #1;
    checkBit("R9 reset wake", wakeOut, 1'b0);
    checkVec("R9 reset status", status, '0);
    @(negedge clk); rstN = 1'b1;

    // R3: event in S0 sets status but no wake
    step("R3 S0 pwrbtn", 3'd0, 0, 28'h1 << 1, '1, '0);
    step("R3 code 6", 3'd6, 0, 28'h1 << 0, '1, '0);
    // R2: clear, and event beats clear
    step("R2 clear", 3'd0, 0, '0, '0, 28'h3);
    step("R2 set wins", 3'd0, 0, 28'h1 << 4, '0, 28'h1 << 4);
    step("R2 clear all", 3'd0, 0, '0, '0, '1);
    // R4: masked source, unmaskable source
    step("R4 rtc disabled", 3'd3, 0, 28'h1 << 0, '0, '0);
    step("R4 alert no enable", 3'd3, 0, 28'h1 << 8, '0, '0);
    step("R4 rtc enabled", 3'd3, 0, 28'h1 << 0, '1, '0);
    // R5: core GPI only from S1
    step("R5 core gpi S2", 3'd2, 0, 28'h1 << 15, '1, '0);
    step("R5 core gpi S1", 3'd1, 0, 28'h1 << 15, '1, '0);
    // R7: software S5 allows resume GPI and USB
    step("R7 resume gpi S5", 3'd5, 0, 28'h1 << 22, '1, '0);
    step("R7 usb S5", 3'd5, 0, 28'h1 << 26, '1, '0);
    step("R7 core gpi S5", 3'd5, 0, 28'h1 << 13, '1, '0);
    // R6/R8: arm override, only the allowed four wake
    step("R8 arm override", 3'd5, 1, '0, '1, '0);
    step("R6 rtc blocked", 3'd5, 0, 28'h1 << 0, '1, '0);
    step("R6 lan blocked", 3'd5, 0, 28'h1 << 2, '1, '0);
    step("R6 usb blocked", 3'd5, 0, 28'h1 << 25, '1, '0);
    step("R6 pwrbtn wakes", 3'd5, 0, 28'h1 << 1, '0, '0);
    step("R6 hard reset", 3'd5, 0, 28'h1 << 11, '0, '0);
    step("R8 back to S0", 3'd0, 0, '0, '0, '1);
    step("R8 software S5 rtc", 3'd5, 0, 28'h1 << 0, '1, '0);

    for (int n = 0; n < 4000; n++) begin
      bit ovrIn = 1'b0;
      logic [W-1:0] ev = '0;
      logic [W-1:0] clr = '0;
      if ($urandom % 8 == 0) begin
        st = 3'($urandom % 8);
        if (st == 3'd5 && $urandom % 2 == 1) ovrIn = 1'b1;
      end
      if ($urandom % 2 == 0) ev[$urandom % W] = 1'b1;
      if ($urandom % 8 == 0) ev[$urandom % W] = 1'b1;
      if ($urandom % 8 == 0) clr = W'($urandom);
      step("R1/R3/R4/R5/R6/R7 random", st, ovrIn, ev, W'($urandom), clr);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule